// File: doc/BRIEF.md
# Stochastic Bipolar Neuron

This block evaluates one neuron of a feed-forward network without any multiplier. Every input and every weight is turned into a pseudo-random bitstream whose share of ones encodes a value in [-1, 1]. Each input stream is multiplied by its weight stream with a single XNOR gate. The M products are summed by a binary tree of toggle-based halving adders. A ones counter converts the tree output back to binary. The decoded count is then mapped to a signed sum, the bias is added, and an optional rectifier is applied.

Each stream generator pairs a K-bit shift register with a comparator. The shift register is extended to visit all 2^K states, the all-zero state included, so one evaluation of N = 2^K cycles sees every random value exactly once. Every generator starts from its own seed, which decorrelates the streams. A host holds the codes, the bias and the mode steady, pulses `start`, and collects the result when `done` pulses. `clear` abandons an evaluation at any time.

Top module: `sc_neuron`

## Requirements
- R1: While reset is held and after its release, `done` is 0 and `y` is 0.
- R2: A generator fed code c (0..N-1, N = 2^K) emits exactly c ones over an evaluation. It emits 1 in a cycle when its random value is below c, so code 0 gives an all-zero stream, which stands for -1.
- R3: The product of lane i (input bits `x_code[i*K +: K]`, weight bits `w_code[i*K +: K]`) is the XNOR of its two streams. When one of the two codes is 0, that product carries exactly N minus the other code ones.
- R4: Each adder node outputs its inputs when they agree. When they differ it outputs its toggle state and then flips that state. The state is 0 at the start of an evaluation, so a node's ones count is floor((a+b)/2) of its input counts. First-level nodes pair lane 2j with lane 2j+1, and later levels pair the node outputs in the same way.
- R5: With count = ones at the tree root (0..N), the result before activation is M*(2*count - N) + bias, with `bias` a signed value on the same scale.
- R6: With `act_relu` = 1, a negative result is output as 0 and a non-negative result passes unchanged. With `act_relu` = 0, every result passes unchanged.
- R7: If `start` is sampled at clock edge E, `done` is high for exactly one cycle after edge E+N+1, and `y` takes its new value at that same edge. Otherwise `y` holds.
- R8: `clear` restarts every generator, node and the counter. It aborts a running evaluation, so no `done` follows, and `y` keeps its previous value.
- R9: A `start` pulse while an evaluation is running has no effect on its timing or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous restart of generators and counter; aborts a run |
| start | input | 1 | Begins an evaluation when idle |
| act_relu | input | 1 | 1 selects rectifier, 0 selects pass-through |
| x_code | input | M*K | Input codes, lane i at bits i*K +: K |
| w_code | input | M*K | Weight codes, lane i at bits i*K +: K |
| bias | input | K+LG_M+2 | Signed bias in result units |
| done | output | 1 | One-cycle pulse when `y` is updated |
| y | output | K+LG_M+3 | Signed activated result |

## Verification
Stochastic streams do not give a closed-form output for arbitrary codes. The hard part is making the adder tree's rounding observable, odd input counts included, with exact expected values. The stimulus therefore gives every lane a zero code on one side. Each product's ones count is then known exactly, and the floor rule for each node lets the bench compute the root count bit-exactly through odd sums. A clear in mid-run and a second start during a run are added to show that neither leaks a spurious `done` or alters `y`.

// File: rtl/sc_neuron_pkg.sv
package sc_neuron_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_FIN} sc_phase_e;

  // feedback mask of a maximal-length shift register of width k (bit p-1 for tap p)
  function automatic logic [15:0] tap_mask(input int k);
    logic [15:0] m;
    case (k)
      4:  m = 16'h000C;
      5:  m = 16'h0014;
      6:  m = 16'h0030;
      7:  m = 16'h0060;
      8:  m = 16'h00B8;
      9:  m = 16'h0110;
      10: m = 16'h0240;
      11: m = 16'h0500;
      12: m = 16'h0E08;
      13: m = 16'h1C80;
      14: m = 16'h3802;
      15: m = 16'h6000;
      default: m = 16'hD008;
    endcase
    return m;
  endfunction

  // distinct start state per generator index
  function automatic int gen_seed(input int g, input int k);
    return (g * 53 + 7) % (1 << k);
  endfunction

  // decoded count -> signed result, bias added, optional rectifier
  function automatic int neuron_result(input int count, input int n, input int m,
                                       input int b, input logic relu);
    int s;
    s = m * (2 * count - n) + b;
    if (relu && s < 0) s = 0;
    return s;
  endfunction

endpackage

// File: rtl/sc_stream_gen.sv
module sc_stream_gen #(
  parameter int K = 8,
  parameter logic [K-1:0] SEED = '0,
  parameter logic [K-1:0] TAPS = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [K-1:0] code,
  output logic         bit_o
);
  logic [K-1:0] rnd;
  logic         fb;

  // zero-state insertion makes the cycle cover all 2^K values
  assign fb = (^(rnd & TAPS)) ^ (rnd[K-2:0] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rnd <= SEED;
    else if (load) rnd <= SEED;
    else if (step) rnd <= {rnd[K-2:0], fb};
  end

  assign bit_o = (rnd < code);
endmodule

// File: rtl/sc_half_node.sv
module sc_half_node (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic step,
  input  logic a,
  input  logic b,
  output logic y
);
  logic tog;

  assign y = (a == b) ? a : tog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 tog <= 1'b0;
    else if (load)              tog <= 1'b0;
    else if (step && (a != b))  tog <= ~tog;
  end
endmodule

// File: rtl/sc_run_ctrl.sv
module sc_run_ctrl
  import sc_neuron_pkg::*;
#(
  parameter int K = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         start,
  input  logic         root_bit,
  output logic         load,
  output logic         step,
  output logic         fin,
  output logic         last_bit,
  output logic [K:0]   count
);
  localparam int N = 1 << K;

  sc_phase_e    ph;
  logic [K-1:0] pos;

  assign load     = clear || (start && ph == PH_IDLE);
  assign step     = (ph == PH_RUN) && !clear;
  assign last_bit = (ph == PH_RUN) && (pos == K'(N - 1));
  assign fin      = (ph == PH_FIN) && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      pos   <= '0;
      count <= '0;
    end else if (clear) begin
      ph    <= PH_IDLE;
      pos   <= '0;
      count <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          ph    <= PH_RUN;
          pos   <= '0;
          count <= '0;
        end
        PH_RUN: begin
          count <= count + {{K{1'b0}}, root_bit};
          pos   <= pos + 1'b1;
          if (last_bit) ph <= PH_FIN;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sc_neuron.sv
module sc_neuron
  import sc_neuron_pkg::*;
#(
  parameter int K    = 8,
  parameter int LG_M = 2,
  localparam int M   = 1 << LG_M,
  localparam int N   = 1 << K,
  localparam int BW  = K + LG_M + 2,
  localparam int YW  = BW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 start,
  input  logic                 act_relu,
  input  logic [M*K-1:0]       x_code,
  input  logic [M*K-1:0]       w_code,
  input  logic signed [BW-1:0] bias,
  output logic                 done,
  output logic signed [YW-1:0] y
);
  localparam logic [K-1:0] TAPS = tap_mask(K)[K-1:0];

  logic         load, step, fin, last_bit;
  logic [K:0]   count;
  logic         xs [M];
  logic         ws [M];
  logic         node [1:2*M-1];

  genvar gi;
  generate
    for (gi = 0; gi < M; gi++) begin : g_lane
      sc_stream_gen #(.K(K), .SEED(K'(gen_seed(gi, K))), .TAPS(TAPS)) u_xgen (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .code(x_code[gi*K +: K]), .bit_o(xs[gi]));
      sc_stream_gen #(.K(K), .SEED(K'(gen_seed(M + gi, K))), .TAPS(TAPS)) u_wgen (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .code(w_code[gi*K +: K]), .bit_o(ws[gi]));
      assign node[M + gi] = ~(xs[gi] ^ ws[gi]);
    end
    for (gi = 1; gi < M; gi++) begin : g_node
      sc_half_node u_add (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .a(node[2*gi]), .b(node[2*gi+1]), .y(node[gi]));
    end
  endgenerate

  sc_run_ctrl #(.K(K)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clear(clear), .start(start),
    .root_bit(node[1]), .load(load), .step(step), .fin(fin),
    .last_bit(last_bit), .count(count));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      y    <= '0;
    end else begin
      done <= fin;
      if (fin) y <= YW'(neuron_result(int'(count), N, M, int'(bias), act_relu));
    end
  end
endmodule

// File: rtl/sc_neuron_chk.sv
module sc_neuron_chk #(
  parameter int K  = 8,
  parameter int YW = 13
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clear,
  input logic                 done,
  input logic                 act_relu,
  input logic signed [YW-1:0] y,
  input logic                 last_bit,
  input logic [K:0]           count
);
  localparam int N = 1 << K;

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !done && y == '0); // R1
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) int'(count) <= N); // R5
  AST_RELU_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(act_relu)) |-> !y[YW-1]); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (last_bit && !clear) ##1 !clear |=> done); // R7
  AST_Y_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !$stable(y) |-> done); // R7
  AST_CLEAR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n) clear |=> !done); // R8
endmodule

bind sc_neuron sc_neuron_chk #(.K(K), .YW(YW)) u_sc_neuron_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .done(done), .act_relu(act_relu),
  .y(y), .last_bit(last_bit), .count(count));

// File: tb/test_sc_neuron.sv
module test_sc_neuron;
  localparam int K    = 8;
  localparam int LG_M = 2;
  localparam int M    = 1 << LG_M;
  localparam int N    = 1 << K;
  localparam int BW   = K + LG_M + 2;
  localparam int YW   = BW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic start = 1'b0;
  logic act_relu = 1'b0;
  logic [M*K-1:0] x_code = '0;
  logic [M*K-1:0] w_code = '0;
  logic signed [BW-1:0] bias = '0;
  logic done;
  logic signed [YW-1:0] y;

  int checks = 0;
  int errors = 0;
  int pcyc = 0;
  int stray = 0;
  bit finished = 0;

  int    q_y[$];
  int    q_cyc[$];
  string q_tag[$];

  always #10 clk = ~clk;
  always @(posedge clk) pcyc <= pcyc + 1;

  sc_neuron #(.K(K), .LG_M(LG_M)) i_sc_neuron (
    .clk(clk), .rst_n(rst_n), .clear(clear), .start(start), .act_relu(act_relu),
    .x_code(x_code), .w_code(w_code), .bias(bias), .done(done), .y(y));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever done is seen
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q_y.size() == 0) begin
        stray++;
        check(0, "R8/R9 unexpected done", 1, 0);
      end else begin
        int ey, ec;
        string t;
        ey = q_y.pop_front();
        ec = q_cyc.pop_front();
        t  = q_tag.pop_front();
        check(int'(y) == ey, {t, " result"}, int'(y), ey);
        check(pcyc == ec, "R7 done cycle", pcyc, ec);
      end
    end
  end

  // reference: exact counts when each lane has a zero code on one side
  function automatic int expect_y(input int xs[M], input int ws[M], input int b, input bit relu);
    int ones [1:2*M-1];
    int s;
    for (int i = 0; i < M; i++)
      ones[M+i] = (xs[i] == 0) ? N - ws[i] : N - xs[i]; // R2 R3
    for (int j = M - 1; j >= 1; j--)
      ones[j] = (ones[2*j] + ones[2*j+1]) / 2;          // R4
    s = M * (2 * ones[1] - N) + b;                      // R5
    if (relu && s < 0) s = 0;                           // R6
    return s;
  endfunction

  task automatic load_ops(input int xs[M], input int ws[M], input int b, input bit relu);
    for (int i = 0; i < M; i++) begin
      x_code[i*K +: K] = K'(xs[i]);
      w_code[i*K +: K] = K'(ws[i]);
    end
    bias = BW'(b);
    act_relu = relu;
  endtask

  task automatic pulse_start();
    @(posedge clk); #2;
    start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  // driver: set operands, push expectation, start, wait for completion
  task automatic run_eval(input int xs[M], input int ws[M], input int b, input bit relu,
                          input string tag);
    @(posedge clk); #2;
    load_ops(xs, ws, b, relu);
    q_y.push_back(expect_y(xs, ws, b, relu));
    q_cyc.push_back(pcyc + N + 2);
    q_tag.push_back(tag);
    start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    repeat (N + 4) @(posedge clk);
  endtask

  initial begin
    int held;
    repeat (3) @(posedge clk);
    #2;
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
    check(y == '0, "R1 y in reset", int'(y), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #2;
    check(done == 1'b0 && y == '0, "R1 after release", int'(y), 0);

    run_eval('{0, 0, 0, 0}, '{0, 0, 0, 0}, 0, 0, "R3 all positive products");
    run_eval('{0, 0, 0, 0}, '{255, 255, 255, 255}, 0, 0, "R2 near -1 products");
    run_eval('{0, 0, 0, 0}, '{255, 255, 255, 255}, 0, 1, "R6 rectified negative");
    run_eval('{0, 0, 0, 0}, '{1, 2, 3, 4}, 0, 0, "R4 odd node sums");
    run_eval('{0, 37, 0, 200}, '{10, 0, 128, 0}, -100, 0, "R3 mixed zero sides");
    run_eval('{0, 37, 0, 200}, '{10, 0, 128, 0}, 500, 1, "R6 positive passes");
    run_eval('{0, 0, 0, 0}, '{0, 0, 0, 0}, 2047, 0, "R5 max bias");
    run_eval('{0, 0, 0, 0}, '{255, 255, 255, 255}, -2048, 0, "R5 min bias");
    run_eval('{5, 0, 0, 99}, '{0, 77, 3, 0}, -2000, 1, "R6 clamp with bias");

    // R8: clear in mid-run, no done, y held
    held = int'(y);
    pulse_start();
    repeat (100) @(posedge clk);
    #2;
    clear = 1'b1;
    @(posedge clk); #2;
    clear = 1'b0;
    repeat (N + 10) @(posedge clk);
    #2;
    check(stray == 0, "R8 no done after clear", stray, 0);
    check(int'(y) == held, "R8 y kept after clear", int'(y), held);

    // R9: second start during run is ignored
    @(posedge clk); #2;
    load_ops('{0, 0, 0, 0}, '{9, 0, 0, 0}, 7, 0);
    q_y.push_back(expect_y('{0, 0, 0, 0}, '{9, 0, 0, 0}, 7, 0));
    q_cyc.push_back(pcyc + N + 2);
    q_tag.push_back("R9 restart ignored");
    start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    repeat (60) @(posedge clk);
    #2;
    start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    repeat (N + 10) @(posedge clk);
    #2;
    check(stray == 0 && q_y.size() == 0, "R9 single done", stray + q_y.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule